// File: doc/BRIEF.md
# Parallel-to-Serial Shifter with Staging Register

This block turns a parallel byte into a serial bit stream using two stages that run on separate clocks. A staging register takes a snapshot of the parallel bus on its own capture clock. A shift chain, clocked independently, receives that snapshot through an asynchronous, level-sensitive load. It then moves the bits out of its last stage one per shift edge, while fresh bits from a serial input fill it from the other end.

Because the snapshot is decoupled from the shift chain, a new byte can be captured while the previous one is still being shifted out. The snapshot is only copied across when the load control goes low. An active-low clear empties the shift chain alone and leaves the staging register untouched. Several instances can be chained by wiring one serial output to the next serial input.

Top module: `piso_stored_shifter`

## Requirements
- R1: On each rising edge of `store_clk` the staging register takes the value of `par_in`. This capture has no effect on the shift chain or on `ser_out` while `load_n` is high.
- R2: While `load_n` is low and `clear_n` is high, the shift chain equals the staging register without any `shift_clk` edge. `ser_out` then shows staging bit WIDTH-1.
- R3: While `load_n` is held low, a new capture on `store_clk` passes straight into the shift chain with no `shift_clk` edge.
- R4: While `clear_n` is low, every stage of the shift chain is 0 and `ser_out` is 0, regardless of the clocks.
- R5: When `clear_n` and `load_n` are both low, the clear wins and `ser_out` is 0. If `clear_n` then rises while `load_n` stays low, the staging value appears in the chain at once.
- R6: On a rising `shift_clk` edge with `load_n` and `clear_n` high, `ser_in` enters stage 0 and stage k moves to stage k+1. `ser_out` is always the last stage, WIDTH-1.
- R7: Rising `shift_clk` edges have no effect while `load_n` is low.
- R8: Neither `clear_n` nor `load_n` changes the staging register. A load after a clear reproduces the last captured byte.
- R9: After a load, WIDTH shift edges present the loaded byte on `ser_out` highest bit first. The next WIDTH edges present the `ser_in` bits in the order they were fed.
- R10: Rising `shift_clk` edges while `clear_n` is low leave the chain at all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| store_clk | input | 1 | Capture clock of the staging register |
| shift_clk | input | 1 | Clock of the shift chain |
| clear_n | input | 1 | Active-low asynchronous clear of the shift chain |
| load_n | input | 1 | Active-low, level-sensitive copy of staging register into shift chain |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | WIDTH | Parallel data captured by the staging register |
| ser_out | output | 1 | Serial data from the last stage |

## Verification
A capture edge and a shift edge can land at the same instant. The bench provokes this by raising `store_clk` and `shift_clk` together after a byte has been loaded. It judges the result by shifting out the chain, which must hold the old byte moved one place, and by then loading, which must reveal the new capture. The overlap of clear and load is exercised the same way: both are lowered together, then released one at a time while `ser_out` is watched.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int unsigned DEF_WIDTH = 8;

    // Per-stage asynchronous override request. Never both set.
    typedef struct packed {
        logic set;
        logic clr;
    } cell_force_t;

    // Clear dominates load. Load drives a stage to the staged bit value.
    function automatic cell_force_t force_for(
        input logic clear_n,
        input logic load_n,
        input logic staged_bit
    );
        cell_force_t f;
        f.clr = !clear_n || (!load_n && !staged_bit);
        f.set = clear_n && !load_n && staged_bit;
        return f;
    endfunction

endpackage

// File: rtl/piso_store_reg.sv
module piso_store_reg #(
    parameter int unsigned WIDTH = piso_pkg::DEF_WIDTH
) (
    input  logic             store_clk,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stored_q
);

    // Plain capture register: not touched by clear or load.
    always_ff @(posedge store_clk) begin
        stored_q <= par_in;
    end

endmodule

// File: rtl/piso_force_decode.sv
module piso_force_decode
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = piso_pkg::DEF_WIDTH
) (
    input  logic                    clear_n,
    input  logic                    load_n,
    input  logic [WIDTH-1:0]        stored_q,
    output cell_force_t [WIDTH-1:0] forces
);

    for (genvar k = 0; k < WIDTH; k++) begin : g_dec
        always_comb begin
            forces[k] = force_for(clear_n, load_n, stored_q[k]);
        end
    end

endmodule

// File: rtl/piso_shift_cell.sv
module piso_shift_cell
    import piso_pkg::*;
(
    input  logic        shift_clk,
    input  cell_force_t frc,
    input  logic        d,
    output logic        q
);

    logic set_i;
    logic clr_i;

    assign set_i = frc.set;
    assign clr_i = frc.clr;

    // Asynchronous set/clear style stage; levels hold the value while active.
    always_ff @(posedge shift_clk or posedge clr_i or posedge set_i) begin
        if (clr_i) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/piso_stored_shifter.sv
module piso_stored_shifter
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = piso_pkg::DEF_WIDTH
) (
    input  logic             store_clk,
    input  logic             shift_clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);

    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0]        stored_q;
    logic [WIDTH-1:0]        shift_q;
    logic [WIDTH-1:0]        shift_d;
    cell_force_t [WIDTH-1:0] forces;

    piso_store_reg #(.WIDTH(WIDTH)) u_store (
        .store_clk (store_clk),
        .par_in    (par_in),
        .stored_q  (stored_q)
    );

    piso_force_decode #(.WIDTH(WIDTH)) u_dec (
        .clear_n  (clear_n),
        .load_n   (load_n),
        .stored_q (stored_q),
        .forces   (forces)
    );

    // Chain wiring: stage 0 from the serial input, others from the stage below.
    assign shift_d = {shift_q[WIDTH-2:0], ser_in};

    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
        piso_shift_cell u_cell (
            .shift_clk (shift_clk),
            .frc       (forces[k]),
            .d         (shift_d[k]),
            .q         (shift_q[k])
        );
    end

    assign ser_out = shift_q[LAST];

endmodule

// File: rtl/piso_stored_shifter_chk.sv
module piso_stored_shifter_chk #(
    parameter int unsigned WIDTH = piso_pkg::DEF_WIDTH
) (
    input logic             store_clk,
    input logic             shift_clk,
    input logic             clear_n,
    input logic             load_n,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stored_q,
    input logic [WIDTH-1:0] shift_q,
    input logic             ser_out
);

    // Marks that a clear or load happened since the last clean shift edge.
    logic async_evt = 1'b1;

    always_ff @(posedge shift_clk or negedge load_n or negedge clear_n) begin
        if (!clear_n) begin
            async_evt <= 1'b1;
        end else if (!load_n) begin
            async_evt <= 1'b1;
        end else begin
            async_evt <= 1'b0;
        end
    end

    // R1: capture on store clock
    assert_capture_R1: assert property (@(posedge store_clk)
        1'b1 |=> stored_q == $past(par_in));

    // R2: load level mirrors staging register
    assert_load_mirror_R2: assert property (@(posedge shift_clk)
        (clear_n && !load_n) |-> shift_q == stored_q);

    // R4: clear holds zeros
    assert_clear_zero_R4: assert property (@(posedge shift_clk)
        !clear_n |-> (shift_q == '0 && !ser_out));

    // R5: clear dominates load
    assert_clear_over_load_R5: assert property (@(posedge store_clk)
        (!clear_n && !load_n) |-> shift_q == '0);

    // R6: clean shift step
    assert_shift_step_R6: assert property (@(posedge shift_clk) disable iff (!clear_n)
        !async_evt |-> shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_in)});

endmodule

bind piso_stored_shifter piso_stored_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .store_clk (store_clk),
    .shift_clk (shift_clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .stored_q  (stored_q),
    .shift_q   (shift_q),
    .ser_out   (ser_out)
);

// File: tb/piso_stored_shifter_tb.sv
module piso_stored_shifter_tb;

    localparam int unsigned W = 8;

    logic         tick = 1'b0;
    logic         store_clk = 1'b0;
    logic         shift_clk = 1'b0;
    logic         clear_n = 1'b0;
    logic         load_n = 1'b1;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    piso_stored_shifter #(.WIDTH(W)) u_dut (
        .store_clk (store_clk),
        .shift_clk (shift_clk),
        .clear_n   (clear_n),
        .load_n    (load_n),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .ser_out   (ser_out)
    );

    always #5 tick = ~tick;  // 100 MHz reference clock

    // {byte captured, serial fill, expected 16-bit stream MSB first}
    localparam logic [31:0] VECS [4] = '{
        {8'hA5, 8'h3C, 16'hA53C},
        {8'h00, 8'hFF, 16'h00FF},
        {8'hFF, 8'h00, 16'hFF00},
        {8'h81, 8'h96, 16'h8196}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic store(input logic [W-1:0] b);
        par_in = b;
        #2 store_clk = 1'b1;
        #3 store_clk = 1'b0;
        #2;
    endtask

    task automatic shift1(input logic b);
        ser_in = b;
        #2 shift_clk = 1'b1;
        #3 shift_clk = 1'b0;
        #2;
    endtask

    task automatic load_pulse();
        load_n = 1'b0;
        #3 load_n = 1'b1;
        #2;
    endtask

    task automatic stream(input logic [15:0] feed, output logic [15:0] got);
        for (int i = 0; i < 16; i++) begin
            got[15-i] = ser_out;
            shift1(feed[15-i]);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge tick);
            if (done) disable watchdog;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] got;
        #12;
        // Reset state
        chk("R4 out during clear", ser_out, 0);
        clear_n = 1'b1;
        #2;
        stream(16'h0000, got);
        chk("R4 chain empty after clear", got, 16'h0000);

        // Vector table
        for (int v = 0; v < 4; v++) begin
            store(VECS[v][31:24]);
            load_n = 1'b0;
            #2;
            chk("R2 load without shift edge", ser_out, VECS[v][31]);
            load_n = 1'b1;
            #2;
            stream({VECS[v][23:16], 8'h00}, got);
            chk("R9 R6 stream order", got, VECS[v][15:0]);
        end

        // R1: capture with load high leaves chain alone
        store(8'hA5);
        load_pulse();
        store(8'h00);
        chk("R1 capture hidden while load high", ser_out, 1);

        // Simultaneous capture and shift edges
        store(8'hC3);
        load_pulse();
        par_in = 8'h3C;
        ser_in = 1'b0;
        #2;
        store_clk = 1'b1;
        shift_clk = 1'b1;
        #3;
        store_clk = 1'b0;
        shift_clk = 1'b0;
        #2;
        chk("R6 shift on coincident edge", ser_out, 1);
        stream(16'h0000, got);
        chk("R6 old byte moved one place", got, 16'h8600);
        load_pulse();
        stream(16'h0000, got);
        chk("R1 coincident capture kept", got, 16'h3C00);

        // R7: shift edges ignored under load
        store(8'h6B);
        load_n = 1'b0;
        #2;
        for (int i = 0; i < 3; i++) shift1(1'b1);
        chk("R7 out held under load", ser_out, 0);
        load_n = 1'b1;
        #2;
        stream(16'h0000, got);
        chk("R7 chain unchanged by shifts", got, 16'h6B00);

        // R3: capture passes through while load low
        load_n = 1'b0;
        store(8'hE1);
        chk("R3 capture through load", ser_out, 1);
        store(8'h1E);
        chk("R3 second capture through load", ser_out, 0);
        load_n = 1'b1;
        #2;
        stream(16'h0000, got);
        chk("R3 chain holds last capture", got, 16'h1E00);

        // R5: clear over load, then release clear
        store(8'hFF);
        clear_n = 1'b0;
        load_n = 1'b0;
        #2;
        chk("R5 clear wins over load", ser_out, 0);
        clear_n = 1'b1;
        #2;
        chk("R5 load after clear release", ser_out, 1);
        load_n = 1'b1;
        #2;
        stream(16'h0000, got);
        chk("R5 full byte after release", got, 16'hFF00);

        // R10: shifts during clear
        store(8'hFF);
        load_pulse();
        clear_n = 1'b0;
        #2;
        shift1(1'b1);
        shift1(1'b1);
        chk("R10 out zero with shifts in clear", ser_out, 0);
        clear_n = 1'b1;
        #2;
        stream(16'h0000, got);
        chk("R10 chain zero after clear shifts", got, 16'h0000);

        // R8: staging survives clear and load
        store(8'h9C);
        clear_n = 1'b0;
        #2 clear_n = 1'b1;
        #2;
        load_pulse();
        load_pulse();
        stream(16'h0000, got);
        chk("R8 staging kept through clear", got, 16'h9C00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule